// File: doc/BRIEF.md
# Scoreboard Adder Computation Unit

An integer add/subtract computation unit for a scoreboard-controlled out-of-order core. A functional-unit controller steps it through one operation with three strobes. The issue strobe latches the operation fields (operand-2 source select, operand-2 invert select, 12-bit immediate, carry-in). The read strobe latches both register operands. The write strobe places the result on a shared result bus that is OR-combined with other units. The unit reports busy, request-read and request-write back to the controller.

Every status output and the result port is a register. Each one changes on the clock edge after the strobe that causes it. The controller, the dependency logic and the register trunk can therefore drive this unit through purely combinational paths without forming loops. The result port is zero in every cycle except the one after an accepted write strobe, so it can feed a wired-OR bus directly. Subtraction is issued as an add with operand 2 inverted and carry-in set.

Top module: `addcu_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busyO, reqReadO, reqWriteO and resultO are all zero.
- R2: An issue strobe seen while busyO is low raises busyO and reqReadO on the next clock edge.
- R3: An issue strobe seen while busyO is high is ignored: the status outputs do not change and the operation fields latched earlier are the ones used for the result.
- R4: A read strobe seen while reqReadO is high latches both register operands and, on the next edge, drops reqReadO and raises reqWriteO.
- R5: A write strobe seen while reqWriteO is high makes resultO carry the sum for exactly the following cycle, and clears busyO and reqWriteO on the same edge.
- R6: In every cycle that does not follow an accepted write strobe, resultO is all zeros.
- R7: The sum is operand1 + addend2 + carry-in, truncated to XLEN bits (wraps modulo 2^XLEN).
- R8: When the latched source select (opImmSelI = 1) is set, addend2 is the 12-bit immediate sign-extended from its bit 11; otherwise it is the second register operand.
- R9: When the latched invert select (opInvertI = 1) is set, addend2 is bitwise inverted after selection; with carry-in 1 this yields operand1 minus the selected operand.
- R10: The sum uses only latched values: changes on the operation-field and operand inputs after their capture strobes have no effect on the result.
- R11: A read strobe outside the request-read phase and a write strobe outside the request-write phase are ignored: no recapture, no status change, and resultO stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| issueI | input | 1 | Issue strobe; latches the operation fields |
| goReadI | input | 1 | Read/sum strobe; latches the register operands |
| goWriteI | input | 1 | Write strobe; drives the result for one cycle |
| opImmSelI | input | 1 | 1 selects the sign-extended immediate as operand 2 |
| opInvertI | input | 1 | 1 inverts operand 2 (used for subtraction) |
| opImmI | input | 12 | Immediate field |
| opCarryI | input | 1 | Carry-in to the adder |
| srcAI | input | XLEN | Register operand 1 |
| srcBI | input | XLEN | Register operand 2 |
| busyO | output | 1 | Unit holds an operation |
| reqReadO | output | 1 | Unit waits for its operands |
| reqWriteO | output | 1 | Unit waits for permission to write |
| resultO | output | XLEN | Result to the OR-combined bus; zero when not writing |

## Verification
Each status output is due one clock edge after its strobe. The result is due in the cycle after the edge that samples an accepted write strobe, and it must be zero in every other cycle. The bench drives strobes on falling edges. It checks status at the next falling edge, after exactly one rising edge. A monitor samples resultO shortly after every rising edge. The monitor pops an expected sum from the scoreboard queue only when the driver has flagged that edge as an accepted write. At every other edge it demands zero, so a result that is early, late or repeated shows up as a mismatch.

// File: rtl/addcu_pkg.sv
package addcu_pkg;

  // Strobes from control to datapath, already qualified by the phase.
  typedef struct packed {
    logic capOp;    // latch operation fields
    logic capOpnd;  // latch register operands
    logic drive;    // load the result register with the sum
  } cuStrobes_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } cuPhase_t;

  typedef struct packed {
    logic immSel;
    logic invert;
    logic carry;
  } opFlags_t;

endpackage

// File: rtl/addcu_ctrl.sv
module addcu_ctrl
  import addcu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueI,
  input  logic       goReadI,
  input  logic       goWriteI,
  output cuStrobes_t strobes,
  output logic       busyO,
  output logic       reqReadO,
  output logic       reqWriteO
);

  cuPhase_t phase, phaseNext;

  // Strobes are honoured only in the phase that expects them.
  always_comb begin
    strobes.capOp   = issueI   && (phase == PH_IDLE);
    strobes.capOpnd = goReadI  && (phase == PH_READ);
    strobes.drive   = goWriteI && (phase == PH_WRITE);
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:  if (issueI)   phaseNext = PH_READ;
      PH_READ:  if (goReadI)  phaseNext = PH_WRITE;
      PH_WRITE: if (goWriteI) phaseNext = PH_IDLE;
      default:                phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  // Status outputs come straight from the phase register.
  assign busyO     = (phase != PH_IDLE);
  assign reqReadO  = (phase == PH_READ);
  assign reqWriteO = (phase == PH_WRITE);

  // R2: issue while idle raises busy and request-read on the next edge
  a_r2_issue_raises_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busyO && issueI) |=> (busyO && reqReadO && !reqWriteO));

  // R3: issue while busy does not disturb the status outputs
  a_r3_issue_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (reqReadO && issueI && !goReadI) |=> (busyO && reqReadO));

  // R4: read strobe hands over from request-read to request-write
  a_r4_read_handover: assert property (@(posedge clk) disable iff (!rstN)
    (reqReadO && goReadI) |=> (busyO && !reqReadO && reqWriteO));

  // R5: write strobe ends the operation on the next edge
  a_r5_write_ends: assert property (@(posedge clk) disable iff (!rstN)
    (reqWriteO && goWriteI) |=> (!busyO && !reqWriteO && !reqReadO));

  // R11: stray write strobe while waiting for operands is ignored
  a_r11_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqReadO && goWriteI && !goReadI) |=> reqReadO);

  // R11: stray read strobe while waiting to write is ignored
  a_r11_stray_read: assert property (@(posedge clk) disable iff (!rstN)
    (reqWriteO && goReadI && !goWriteI) |=> reqWriteO);

  // R4: the two requests are never raised together, and only while busy
  a_r4_req_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqReadO, reqWriteO}) && ((reqReadO || reqWriteO) == busyO));

endmodule

// File: rtl/addcu_addend.sv
module addcu_addend
  import addcu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 12
) (
  input  opFlags_t            flags,
  input  logic [IMM_W-1:0]    imm,
  input  logic [XLEN-1:0]     opndB,
  output logic [XLEN-1:0]     addend
);

  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] picked;

  // Sign extension of the immediate; the variant depends on the widths.
  generate
    if (EXT_W > 0) begin : g_ext
      assign immExt = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign immExt = imm[XLEN-1:0];
    end
  endgenerate

  assign picked = flags.immSel ? immExt : opndB;
  assign addend = flags.invert ? ~picked : picked;

endmodule

// File: rtl/addcu_datapath.sv
module addcu_datapath
  import addcu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  cuStrobes_t       strobes,
  input  logic             opImmSelI,
  input  logic             opInvertI,
  input  logic [IMM_W-1:0] opImmI,
  input  logic             opCarryI,
  input  logic [XLEN-1:0]  srcAI,
  input  logic [XLEN-1:0]  srcBI,
  output logic [XLEN-1:0]  resultO
);

  opFlags_t         flagsQ;
  logic [IMM_W-1:0] immQ;
  logic [XLEN-1:0]  opndAQ;
  logic [XLEN-1:0]  opndBQ;
  logic [XLEN-1:0]  addend2;
  logic [XLEN-1:0]  sum;

  // Operation fields, latched on an accepted issue.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      immQ   <= '0;
    end else if (strobes.capOp) begin
      flagsQ <= '{immSel: opImmSelI, invert: opInvertI, carry: opCarryI};
      immQ   <= opImmI;
    end
  end

  // Register operands, latched on an accepted read strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opndAQ <= '0;
      opndBQ <= '0;
    end else if (strobes.capOpnd) begin
      opndAQ <= srcAI;
      opndBQ <= srcBI;
    end
  end

  addcu_addend #(.XLEN(XLEN), .IMM_W(IMM_W)) u_addend (
    .flags  (flagsQ),
    .imm    (immQ),
    .opndB  (opndBQ),
    .addend (addend2)
  );

  // Sum from latched values only; the carry is zero-extended.
  assign sum = opndAQ + addend2 + {{(XLEN-1){1'b0}}, flagsQ.carry};

  // Result register feeds an OR-combined bus: zero unless writing.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              resultO <= '0;
    else if (strobes.drive) resultO <= sum;
    else                    resultO <= '0;
  end

  // R6: no accepted write strobe means the bus sees zero next cycle
  a_r6_bus_zero: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.drive |=> (resultO == '0));

  // R10: latched operands hold unless a capture strobe arrives
  a_r10_opnd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capOpnd |=> ($stable(opndAQ) && $stable(opndBQ)));

  // R3: operation fields hold unless an issue is accepted
  a_r3_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capOp |=> ($stable(flagsQ) && $stable(immQ)));

endmodule

// File: rtl/addcu_top.sv
module addcu_top
  import addcu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueI,
  input  logic             goReadI,
  input  logic             goWriteI,
  input  logic             opImmSelI,
  input  logic             opInvertI,
  input  logic [IMM_W-1:0] opImmI,
  input  logic             opCarryI,
  input  logic [XLEN-1:0]  srcAI,
  input  logic [XLEN-1:0]  srcBI,
  output logic             busyO,
  output logic             reqReadO,
  output logic             reqWriteO,
  output logic [XLEN-1:0]  resultO
);

  cuStrobes_t strobes;

  addcu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .issueI    (issueI),
    .goReadI   (goReadI),
    .goWriteI  (goWriteI),
    .strobes   (strobes),
    .busyO     (busyO),
    .reqReadO  (reqReadO),
    .reqWriteO (reqWriteO)
  );

  addcu_datapath #(.XLEN(XLEN), .IMM_W(IMM_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .opImmSelI (opImmSelI),
    .opInvertI (opInvertI),
    .opImmI    (opImmI),
    .opCarryI  (opCarryI),
    .srcAI     (srcAI),
    .srcBI     (srcBI),
    .resultO   (resultO)
  );

  // R5: a result on the bus always ends the operation
  a_r5_result_idle: assert property (@(posedge clk) disable iff (!rstN)
    (resultO != '0) |-> (!busyO || reqReadO));

endmodule

// File: tb/addcu_top_tb.sv
module addcu_top_tb;

  localparam int XLEN  = 64;
  localparam int IMM_W = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             issueI = 1'b0, goReadI = 1'b0, goWriteI = 1'b0;
  logic             opImmSelI = 1'b0, opInvertI = 1'b0, opCarryI = 1'b0;
  logic [IMM_W-1:0] opImmI = '0;
  logic [XLEN-1:0]  srcAI = '0, srcBI = '0;
  logic             busyO, reqReadO, reqWriteO;
  logic [XLEN-1:0]  resultO;

  int compared = 0;
  int mismatched = 0;
  bit monitorOn = 1'b0;
  bit writeDue = 1'b0;           // driver flags an accepted write strobe
  logic [XLEN-1:0] expQ[$];

  always #5 clk = ~clk;

  addcu_top #(.XLEN(XLEN), .IMM_W(IMM_W)) u_dut (
    .clk(clk), .rstN(rstN), .issueI(issueI), .goReadI(goReadI),
    .goWriteI(goWriteI), .opImmSelI(opImmSelI), .opInvertI(opInvertI),
    .opImmI(opImmI), .opCarryI(opCarryI), .srcAI(srcAI), .srcBI(srcBI),
    .busyO(busyO), .reqReadO(reqReadO), .reqWriteO(reqWriteO),
    .resultO(resultO)
  );

  function automatic logic [XLEN-1:0] model(bit immSel, bit inv,
      logic [IMM_W-1:0] imm, bit cin, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    logic [XLEN-1:0] o2;
    o2 = immSel ? {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm} : b;
    if (inv) o2 = ~o2;
    return a + o2 + XLEN'(cin);
  endfunction

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkStatus(string req, bit b, bit rr, bit rw);
    check(req, XLEN'({busyO, reqReadO, reqWriteO}), XLEN'({b, rr, rw}));
  endtask

  // Monitor: after each rising edge, pop an expected sum if the driver
  // flagged an accepted write for that edge, otherwise demand zero.
  initial begin
    forever begin
      @(posedge clk);
      if (monitorOn) begin
        bit due;
        due = writeDue;
        #2;
        if (due) begin
          if (expQ.size() == 0) check("R5 queue", resultO, '0);
          else check("R5/R7 result", resultO, expQ.pop_front());
        end else begin
          check("R6 idle bus", resultO, '0);
        end
      end
    end
  end

  // Full operation with optional disturbances between strobes.
  task automatic runOp(string tag, bit immSel, bit inv, logic [IMM_W-1:0] imm,
      bit cin, logic [XLEN-1:0] a, logic [XLEN-1:0] b, int readGap,
      bit strayIssue, bit strayWrite, bit strayRead);
    logic [XLEN-1:0] exp;
    exp = model(immSel, inv, imm, cin, a, b);
    @(negedge clk);
    issueI = 1'b1; opImmSelI = immSel; opInvertI = inv; opImmI = imm; opCarryI = cin;
    @(negedge clk);
    issueI = 1'b0;
    // R10: scramble the operation-field inputs after capture
    opImmSelI = ~immSel; opInvertI = ~inv; opImmI = ~imm; opCarryI = ~cin;
    checkStatus({"R2 issue ", tag}, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < readGap; i++) begin
      @(negedge clk);
      checkStatus("R4 waits for read", 1'b1, 1'b1, 1'b0);
    end
    if (strayIssue) begin
      issueI = 1'b1; opImmSelI = 1'b1; opInvertI = 1'b1; opImmI = 12'h5A5;
      @(negedge clk);
      issueI = 1'b0;
      checkStatus("R3 issue while busy", 1'b1, 1'b1, 1'b0);
    end
    if (strayWrite) begin
      goWriteI = 1'b1;          // not flagged: monitor expects zero (R11)
      @(negedge clk);
      goWriteI = 1'b0;
      checkStatus("R11 stray write", 1'b1, 1'b1, 1'b0);
    end
    goReadI = 1'b1; srcAI = a; srcBI = b;
    @(negedge clk);
    goReadI = 1'b0;
    srcAI = ~a; srcBI = a ^ b ^ 64'h1234;   // R10: live inputs change
    checkStatus({"R4 read ", tag}, 1'b1, 1'b0, 1'b1);
    if (strayRead) begin
      goReadI = 1'b1; srcAI = 64'hDEAD; srcBI = 64'hBEEF;
      @(negedge clk);
      goReadI = 1'b0;
      checkStatus("R11 stray read", 1'b1, 1'b0, 1'b1);
    end
    goWriteI = 1'b1; writeDue = 1'b1; expQ.push_back(exp);
    @(negedge clk);
    goWriteI = 1'b0; writeDue = 1'b0;
    checkStatus({"R5 write ", tag}, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkStatus("R1 in reset", 1'b0, 1'b0, 1'b0);
    check("R1 result in reset", resultO, '0);
    rstN = 1'b1;
    @(negedge clk);
    checkStatus("R1 after reset", 1'b0, 1'b0, 1'b0);
    check("R1 result after reset", resultO, '0);
    monitorOn = 1'b1;
    // stray strobes while idle are ignored (R11)
    goReadI = 1'b1; goWriteI = 1'b1;
    @(negedge clk);
    goReadI = 1'b0; goWriteI = 1'b0;
    checkStatus("R11 strobes while idle", 1'b0, 1'b0, 1'b0);

    runOp("R7 add",           0, 0, 12'h000, 0, 64'd1000, 64'd234, 0, 0, 0, 0);
    runOp("R7 carry-in",      0, 0, 12'h000, 1, 64'h10, 64'h20, 2, 0, 0, 0);
    runOp("R7 wrap",          0, 0, 12'h000, 0, '1, 64'd1, 0, 0, 0, 0);
    runOp("R8 imm positive",  1, 0, 12'h7FF, 0, 64'd5, 64'hFFFF, 1, 0, 0, 0);
    runOp("R8 imm negative",  1, 0, 12'h800, 0, 64'd5000, 64'h1, 0, 0, 0, 0);
    runOp("R9 subtract",      0, 1, 12'h000, 1, 64'd300, 64'd500, 0, 0, 0, 0);
    runOp("R9 sub imm",       1, 1, 12'hFFF, 1, 64'd7, 64'd0, 0, 0, 0, 0);
    runOp("R3 stray issue",   0, 0, 12'h000, 0, 64'hAB, 64'hCD, 0, 1, 0, 0);
    runOp("R11 stray strobes",0, 1, 12'h000, 1, 64'h100, 64'h1, 1, 0, 1, 1);
    runOp("R10 back to back", 1, 0, 12'h123, 1, 64'h8000_0000_0000_0000, 64'h0, 0, 1, 1, 1);
    repeat (3) @(negedge clk);
    check("R6 queue drained", XLEN'(expQ.size()), '0);
    monitorOn = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule